// File: doc/BRIEF.md
# ISA Byte-Lane Steering IO Bridge

The bridge converts single accesses from a 32-bit processor bus into cycles on a 16-bit ISA-style peripheral bus. It has two address regions. The general region reaches ports whose odd bytes normally come back on the high data lane. The word-spaced region serves the legacy serial and parallel register groups, where each register sits four processor bytes apart and always uses the low lane. From the processor offset and the requested size, the bridge works out the peripheral port, the lane strobes and the data steering. It then runs one or two strobed cycles of fixed length and returns a one-cycle done pulse. On a read, the result is zero-extended into the 32-bit word.

A processor full-word access aimed at the even partner of an odd port gets special treatment. It becomes a byte cycle to the odd port on the low lane (peripheral address bit 0 raised, byte on bits 7:0). This lets a 16-bit peripheral that expects every byte on the low lane reach its odd registers. A separate size code asks for a 32-bit transfer. The bridge performs it as two halfword cycles, low half first. Accesses that cannot be mapped complete at once with no peripheral cycle, and they set a sticky error flag.

The controller has five states: IDLE, STROBE, TURN, DONE and FAULT. Its transitions are:
- IDLE to STROBE: a legal request arrives.
- IDLE to FAULT: an illegal request arrives.
- STROBE to TURN: the last strobe clock of the first half of a pair.
- STROBE to DONE: the last strobe clock of any other cycle.
- TURN to STROBE: the second half of a pair starts.
- DONE to IDLE and FAULT to IDLE: unconditional.

Top module: `isa_lane_bridge`

## Requirements
- R1: After reset the following are all low: `io_rd`, `io_wr`, `io_oe`, `io_lane`, `cpu_done` and `cpu_err`.
- R2: This requirement covers a general-region byte access with `cpu_addr[PW+2]`=0, `cpu_addr[PW+1]`=0, `cpu_addr[1]`=0, `cpu_addr[0]`=0 and `cpu_size`=0. The port is {`cpu_addr[PW:2]`,0}, and `io_lane`=01 (bit 0 is the low lane). The write byte `cpu_wdata[7:0]` drives `io_dout[7:0]`, with zeros above it. A read returns `io_din[7:0]` zero-extended.
- R3: A general-region byte access with `cpu_addr[0]`=1 targets port {`cpu_addr[PW:2]`,1} with `io_lane`=10. It writes `cpu_wdata[7:0]` on `io_dout[15:8]`, with zeros below it. A read returns `io_din[15:8]` zero-extended.
- R4: A general-region access with `cpu_size`=2 (full word) and `cpu_addr[0]`=0 targets port {`cpu_addr[PW:2]`,1} with `io_lane`=01. The byte moves on bits 7:0 in both directions.
- R5: A general-region access with `cpu_size`=1 (halfword) and `cpu_addr[0]`=0 targets the even port with `io_lane`=11 and 16 data bits. A read returns the 16 bits zero-extended.
- R6: A general-region access with `cpu_size`=3 (pair) and `cpu_addr[2]`=`cpu_addr[0]`=0 runs two halfword cycles. The first is at the port and the second at port+2. A write sends `cpu_wdata[15:0]` first and then `cpu_wdata[31:16]`. A read returns {second, first}.
- R7: In the word-spaced region (`cpu_addr[PW+2]`=1) the port is `cpu_addr[PW+1:2]`. Only ports in the 8-port groups at 0x3F8, 0x2F8 and 0x378, with `cpu_addr[1:0]`=0, are legal. There a byte uses `io_lane`=01 and a halfword uses `io_lane`=11. Sizes 2 and 3 are illegal.
- R8: Each peripheral cycle holds exactly one of `io_rd` (read) or `io_wr` (write) high for STROBE_CYC clocks. `io_addr` and `io_lane` stay stable throughout, and `io_oe` equals `io_wr`.
- R9: `cpu_done` pulses for one clock, one clock after the last strobe clock. On reads, `cpu_rdata` is valid in that clock.
- R10: The following are illegal:
  - in the general region, `cpu_addr[PW+1]`=1 or `cpu_addr[1]`=1;
  - a halfword or word access with `cpu_addr[0]`=1;
  - a pair access with `cpu_addr[2]` or `cpu_addr[0]` set;
  - any access that R7 rejects.
  An illegal access strobes nothing and pulses `cpu_done` one clock after it is accepted. It sets `cpu_err`, and `cpu_err` stays high until `err_clr`.
- R11: A request that arrives while a transfer is in progress is ignored. It causes no extra cycle, no extra done pulse and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Request, sampled while idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 pair |
| cpu_addr | input | PW+3 | Offset in the IO window; the top bit selects the word-spaced region |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Zero-extended read data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_err | output | 1 | Sticky illegal-access flag |
| err_clr | input | 1 | Clears `cpu_err` |
| io_addr | output | PW | Peripheral port address |
| io_rd | output | 1 | Read strobe |
| io_wr | output | 1 | Write strobe |
| io_lane | output | 2 | Lane enables, bit 0 low byte, bit 1 high byte |
| io_dout | output | 16 | Peripheral write data |
| io_oe | output | 1 | Data drive enable |
| io_din | input | 16 | Peripheral read data |

## Verification
The assertions assume two things about the inputs. First, `io_din` holds still while a read strobe is high. Second, `err_clr` is not the only thing that keeps the error flag under watch: the flag may rise on its own only when an illegal request is taken. The stimulus meets both points:
- The bench's peripheral model derives `io_din` purely from `io_addr`, which the bridge holds steady during a strobe.
- `err_clr` is pulsed only while the bridge is idle with no request pending.
- Requests are raised and dropped on falling clock edges.
- The one overlapping request is deliberately kept inside a transfer to show that it is ignored.

// File: rtl/isa_br_pkg.sv
package isa_br_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_PAIR = 2'd3
    } xfer_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STROBE,
        ST_TURN,
        ST_DONE,
        ST_FAULT
    } br_state_e;

    typedef enum logic [1:0] {
        RS_LOW,
        RS_HIGH,
        RS_HALF
    } lane_sel_e;

    localparam int unsigned WS_GROUPS = 3;
    localparam logic [9:0] WS_BASE [WS_GROUPS] = '{10'h3F8, 10'h2F8, 10'h378};

endpackage

// File: rtl/isa_io_decode.sv
module isa_io_decode
    import isa_br_pkg::*;
#(
    parameter int unsigned PW = 10,
    localparam int unsigned AW = PW + 3
) (
    input  logic [AW-1:0] addr,
    input  xfer_size_e    size,
    output logic          legal,
    output logic [PW-1:0] port,
    output logic [1:0]    lanes,
    output lane_sel_e     rsel,
    output logic          pair
);

    logic [WS_GROUPS-1:0] grp_hit;
    logic                 ws_region;

    assign ws_region = addr[PW+2];

    for (genvar g = 0; g < WS_GROUPS; g++) begin : g_ws
        localparam logic [PW-1:0] GB = PW'(WS_BASE[g]);
        assign grp_hit[g] = (addr[PW+1:5] == GB[PW-1:3]);
    end

    always_comb begin
        legal = 1'b0;
        port  = '0;
        lanes = 2'b00;
        rsel  = RS_LOW;
        pair  = 1'b0;
        if (ws_region) begin
            port = addr[PW+1:2];
            if ((|grp_hit) && (addr[1:0] == 2'b00)) begin
                unique case (size)
                    SZ_BYTE: begin
                        legal = 1'b1;
                        lanes = 2'b01;
                    end
                    SZ_HALF: begin
                        legal = 1'b1;
                        lanes = 2'b11;
                        rsel  = RS_HALF;
                    end
                    default: legal = 1'b0;
                endcase
            end
        end else if (!addr[PW+1] && !addr[1]) begin
            port = {addr[PW:2], 1'b0};
            unique case (size)
                SZ_BYTE: begin
                    legal = 1'b1;
                    if (addr[0]) begin
                        port[0] = 1'b1;
                        lanes   = 2'b10;
                        rsel    = RS_HIGH;
                    end else begin
                        lanes = 2'b01;
                    end
                end
                SZ_HALF: begin
                    legal = !addr[0];
                    lanes = 2'b11;
                    rsel  = RS_HALF;
                end
                SZ_WORD: begin
                    legal   = !addr[0];
                    port[0] = 1'b1;
                    lanes   = 2'b01;
                end
                SZ_PAIR: begin
                    legal = !addr[0] && !addr[2];
                    lanes = 2'b11;
                    rsel  = RS_HALF;
                    pair  = 1'b1;
                end
                default: legal = 1'b0;
            endcase
        end
    end

    always_comb begin
        if (legal && pair) begin
            a_r6_pair_aligned: assert (port[1:0] == 2'b00);
        end
        if (legal && ws_region) begin
            a_r7_ws_low_lane: assert (lanes[0] && !pair);
        end
    end

endmodule

// File: rtl/isa_strobe_timer.sv
module isa_strobe_timer #(
    parameter int unsigned CYC = 3,
    localparam int unsigned CW = (CYC < 2) ? 1 : $clog2(CYC)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign last = run && (cnt_q == CW'(CYC - 1));

    a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_q) < CYC);

    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);

endmodule

// File: rtl/isa_lane_steer.sv
module isa_lane_steer
    import isa_br_pkg::*;
(
    input  lane_sel_e   rsel,
    input  logic        upper,
    input  logic [31:0] wdata,
    input  logic [15:0] din,
    output logic [15:0] dout,
    output logic [15:0] rd_val
);

    always_comb begin
        if (upper) begin
            dout = wdata[31:16];
        end else begin
            unique case (rsel)
                RS_HIGH: dout = {wdata[7:0], 8'h00};
                RS_HALF: dout = wdata[15:0];
                default: dout = {8'h00, wdata[7:0]};
            endcase
        end
    end

    always_comb begin
        unique case (rsel)
            RS_HIGH: rd_val = {8'h00, din[15:8]};
            RS_HALF: rd_val = din;
            default: rd_val = {8'h00, din[7:0]};
        endcase
    end

endmodule

// File: rtl/isa_lane_bridge.sv
module isa_lane_bridge
    import isa_br_pkg::*;
#(
    parameter int unsigned PW = 10,
    parameter int unsigned STROBE_CYC = 3,
    localparam int unsigned AW = PW + 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [1:0]    cpu_size,
    input  logic [AW-1:0] cpu_addr,
    input  logic [31:0]   cpu_wdata,
    output logic [31:0]   cpu_rdata,
    output logic          cpu_done,
    output logic          cpu_err,
    input  logic          err_clr,
    output logic [PW-1:0] io_addr,
    output logic          io_rd,
    output logic          io_wr,
    output logic [1:0]    io_lane,
    output logic [15:0]   io_dout,
    output logic          io_oe,
    input  logic [15:0]   io_din
);

    br_state_e     state_q, state_d;
    logic          dec_legal, dec_pair;
    logic [PW-1:0] dec_port;
    logic [1:0]    dec_lanes;
    lane_sel_e     dec_rsel;

    logic          we_q, pair_q, second_q, err_q;
    logic [PW-1:0] port_q;
    logic [1:0]    lanes_q;
    lane_sel_e     rsel_q;
    logic [31:0]   wdata_q, rdata_q;
    logic [15:0]   steer_dout, rd_val;
    logic          strobe_last, strobing, accept;

    isa_io_decode #(.PW(PW)) u_dec (
        .addr  (cpu_addr),
        .size  (xfer_size_e'(cpu_size)),
        .legal (dec_legal),
        .port  (dec_port),
        .lanes (dec_lanes),
        .rsel  (dec_rsel),
        .pair  (dec_pair)
    );

    assign strobing = (state_q == ST_STROBE);
    assign accept   = (state_q == ST_IDLE) && cpu_req;

    isa_strobe_timer #(.CYC(STROBE_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (strobing),
        .last  (strobe_last)
    );

    isa_lane_steer u_steer (
        .rsel   (rsel_q),
        .upper  (second_q),
        .wdata  (wdata_q),
        .din    (io_din),
        .dout   (steer_dout),
        .rd_val (rd_val)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) state_d = dec_legal ? ST_STROBE : ST_FAULT;
            end
            ST_STROBE: begin
                if (strobe_last) state_d = (pair_q && !second_q) ? ST_TURN : ST_DONE;
            end
            ST_TURN:  state_d = ST_STROBE;
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // transfer context and read assembly
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q     <= 1'b0;
            pair_q   <= 1'b0;
            second_q <= 1'b0;
            port_q   <= '0;
            lanes_q  <= 2'b00;
            rsel_q   <= RS_LOW;
            wdata_q  <= '0;
            rdata_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cpu_req && dec_legal) begin
                        we_q     <= cpu_we;
                        pair_q   <= dec_pair;
                        second_q <= 1'b0;
                        port_q   <= dec_port;
                        lanes_q  <= dec_lanes;
                        rsel_q   <= dec_rsel;
                        wdata_q  <= cpu_wdata;
                    end
                end
                ST_STROBE: begin
                    if (strobe_last && !we_q) begin
                        if (second_q) rdata_q[31:16] <= io_din;
                        else          rdata_q        <= {16'h0000, rd_val};
                    end
                end
                ST_TURN: begin
                    second_q <= 1'b1;
                    port_q   <= port_q + PW'(2);
                end
                default: ;
            endcase
        end
    end

    // sticky error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  err_q <= 1'b0;
        else if (accept && !dec_legal) err_q <= 1'b1;
        else if (err_clr)            err_q <= 1'b0;
    end

    // outputs
    always_comb begin
        io_rd     = strobing && !we_q;
        io_wr     = strobing && we_q;
        io_oe     = strobing && we_q;
        io_lane   = strobing ? lanes_q : 2'b00;
        io_addr   = port_q;
        io_dout   = steer_dout;
        cpu_done  = (state_q == ST_DONE) || (state_q == ST_FAULT);
        cpu_rdata = rdata_q;
        cpu_err   = err_q;
    end

    a_r8_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_rd && io_wr));

    a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd || io_wr) && $past(io_rd || io_wr) |-> $stable(io_addr) && $stable(io_lane));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    a_r10_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_err && !err_clr |=> cpu_err);

    a_r10_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !dec_legal |=> cpu_done && !io_rd && !io_wr);

    a_r11_busy_no_err: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd || io_wr) && !cpu_err |=> !cpu_err);

endmodule

// File: tb/sim_isa_lane_bridge.sv
`timescale 1ns/100ps
module sim_isa_lane_bridge;
    localparam int STROBE = 3;

    typedef struct {
        logic [9:0]  addr;
        logic [1:0]  lanes;
        logic        wr;
        logic [15:0] dout;
        string       tag;
    } bus_item_t;

    typedef struct {
        logic [31:0] rdata;
        logic        chk;
        logic        err;
        string       tag;
    } done_item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, err_clr = 1'b0;
    logic [1:0]  cpu_size = 2'd0;
    logic [12:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] cpu_rdata;
    logic        cpu_done, cpu_err, io_rd, io_wr, io_oe;
    logic [9:0]  io_addr;
    logic [1:0]  io_lane;
    logic [15:0] io_dout, io_din;

    int checks = 0, fails = 0, run_len = 0, cycles = 0;
    logic prev_act = 1'b0, exp_err = 1'b0, finished = 1'b0;
    bus_item_t  bus_q[$];
    done_item_t done_q[$];

    always #2.5 clk = ~clk;

    assign io_din = {io_addr[7:0] ^ 8'hC3, io_addr[7:0] ^ 8'h3C};

    isa_lane_bridge #(.PW(10), .STROBE_CYC(STROBE)) u0 (
        .clk, .rst_n, .cpu_req, .cpu_we, .cpu_size, .cpu_addr, .cpu_wdata,
        .cpu_rdata, .cpu_done, .cpu_err, .err_clr, .io_addr, .io_rd, .io_wr,
        .io_lane, .io_dout, .io_oe, .io_din
    );

    function automatic logic [15:0] din_of(input logic [9:0] p);
        return {p[7:0] ^ 8'hC3, p[7:0] ^ 8'h3C};
    endfunction

    function automatic logic [12:0] gaddr(input logic [9:0] p, input logic b0);
        return {2'b00, p[9:1], 1'b0, b0};
    endfunction

    function automatic logic [12:0] waddr(input logic [9:0] p);
        return {1'b1, p, 2'b00};
    endfunction

    function automatic void check(input bit ok, input string tag,
                                  input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endfunction

    function automatic void exp_bus(input logic [9:0] a, input logic [1:0] l,
                                    input logic wr, input logic [15:0] d, input string tag);
        bus_item_t it;
        it.addr = a; it.lanes = l; it.wr = wr; it.dout = d; it.tag = tag;
        bus_q.push_back(it);
    endfunction

    function automatic void exp_done(input logic [31:0] rd, input logic chk, input string tag);
        done_item_t it;
        it.rdata = rd; it.chk = chk; it.err = exp_err; it.tag = tag;
        done_q.push_back(it);
    endfunction

    // monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic act;
            act = io_rd || io_wr;
            if (act && !prev_act) begin
                if (bus_q.size() == 0) begin
                    check(1'b0, "R11 unexpected cycle", {22'h0, io_addr}, 32'h0);
                end else begin
                    bus_item_t e;
                    e = bus_q.pop_front();
                    check(io_addr == e.addr, {e.tag, " addr"}, {22'h0, io_addr}, {22'h0, e.addr});
                    check(io_lane == e.lanes, {e.tag, " lane"}, {30'h0, io_lane}, {30'h0, e.lanes});
                    check(io_wr == e.wr && io_oe == e.wr, {e.tag, " R8 dir"},
                          {30'h0, io_wr, io_oe}, {30'h0, e.wr, e.wr});
                    if (e.wr)
                        check(io_dout == e.dout, {e.tag, " data"}, {16'h0, io_dout}, {16'h0, e.dout});
                end
            end
            if (act) run_len++;
            else if (run_len != 0) begin
                check(run_len == STROBE, "R8 strobe length", run_len, STROBE);
                run_len = 0;
            end
            prev_act = act;
            if (cpu_done) begin
                if (done_q.size() == 0) begin
                    check(1'b0, "R11 unexpected done", 32'h1, 32'h0);
                end else begin
                    done_item_t d;
                    d = done_q.pop_front();
                    check(cpu_err == d.err, {d.tag, " R10 err"}, {31'h0, cpu_err}, {31'h0, d.err});
                    if (d.chk)
                        check(cpu_rdata == d.rdata, {d.tag, " R9 rdata"}, cpu_rdata, d.rdata);
                end
            end
        end
    end

    task automatic issue(input logic we, input logic [1:0] sz,
                         input logic [12:0] a, input logic [31:0] wd);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_size = sz; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        while (!cpu_done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic illegal(input logic [1:0] sz, input logic [12:0] a, input string tag);
        exp_err = 1'b1;
        exp_done(32'h0, 1'b0, tag);
        issue(1'b0, sz, a, 32'h0);
    endtask

    task automatic clear_err();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        exp_err = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            check(1'b0, "watchdog", cycles, 20000);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!io_rd && !io_wr && !io_oe && io_lane == 2'b00, "R1 strobes",
              {29'h0, io_rd, io_wr, io_oe}, 32'h0);
        check(!cpu_done && !cpu_err, "R1 status", {30'h0, cpu_done, cpu_err}, 32'h0);

        // R2 even byte
        exp_bus(10'h220, 2'b01, 1'b1, 16'h00A5, "R2 wr");
        exp_done(32'h0, 1'b0, "R2 wr");
        issue(1'b1, 2'd0, gaddr(10'h220, 1'b0), 32'hFFFF_FFA5);
        exp_bus(10'h300, 2'b01, 1'b0, 16'h0, "R2 rd");
        exp_done({24'h0, din_of(10'h300)[7:0]}, 1'b1, "R2 rd");
        issue(1'b0, 2'd0, gaddr(10'h300, 1'b0), 32'h0);

        // R3 odd byte on high lane
        exp_bus(10'h279, 2'b10, 1'b1, 16'h5A00, "R3 wr");
        exp_done(32'h0, 1'b0, "R3 wr");
        issue(1'b1, 2'd0, gaddr(10'h278, 1'b1), 32'h0000_005A);
        exp_bus(10'h203, 2'b10, 1'b0, 16'h0, "R3 rd");
        exp_done({24'h0, din_of(10'h203)[15:8]}, 1'b1, "R3 rd");
        issue(1'b0, 2'd0, gaddr(10'h202, 1'b1), 32'h0);

        // R4 full-word access to even partner
        exp_bus(10'h3E1, 2'b01, 1'b1, 16'h0077, "R4 wr");
        exp_done(32'h0, 1'b0, "R4 wr");
        issue(1'b1, 2'd2, gaddr(10'h3E0, 1'b0), 32'h1234_5677);
        exp_bus(10'h221, 2'b01, 1'b0, 16'h0, "R4 rd");
        exp_done({24'h0, din_of(10'h221)[7:0]}, 1'b1, "R4 rd");
        issue(1'b0, 2'd2, gaddr(10'h220, 1'b0), 32'h0);

        // R5 halfword
        exp_bus(10'h220, 2'b11, 1'b1, 16'h1234, "R5 wr");
        exp_done(32'h0, 1'b0, "R5 wr");
        issue(1'b1, 2'd1, gaddr(10'h220, 1'b0), 32'hFFFF_1234);
        exp_bus(10'h236, 2'b11, 1'b0, 16'h0, "R5 rd");
        exp_done({16'h0, din_of(10'h236)}, 1'b1, "R5 rd");
        issue(1'b0, 2'd1, gaddr(10'h236, 1'b0), 32'h0);

        // R10 illegal forms, sticky error
        illegal(2'd1, gaddr(10'h220, 1'b1), "R10 odd half");
        exp_bus(10'h220, 2'b01, 1'b0, 16'h0, "R10 sticky");
        exp_done({24'h0, din_of(10'h220)[7:0]}, 1'b1, "R10 sticky");
        issue(1'b0, 2'd0, gaddr(10'h220, 1'b0), 32'h0);
        clear_err();
        check(!cpu_err, "R10 clear", {31'h0, cpu_err}, 32'h0);
        illegal(2'd2, gaddr(10'h220, 1'b1), "R10 odd word");
        clear_err();
        illegal(2'd0, gaddr(10'h220, 1'b0) | 13'h0002, "R10 addr bit1");
        clear_err();
        illegal(2'd0, gaddr(10'h220, 1'b0) | 13'h0800, "R10 addr bit11");
        clear_err();

        // R6 pair
        exp_bus(10'h224, 2'b11, 1'b1, 16'hBEEF, "R6 wr lo");
        exp_bus(10'h226, 2'b11, 1'b1, 16'hDEAD, "R6 wr hi");
        exp_done(32'h0, 1'b0, "R6 wr");
        issue(1'b1, 2'd3, gaddr(10'h224, 1'b0), 32'hDEAD_BEEF);
        exp_bus(10'h300, 2'b11, 1'b0, 16'h0, "R6 rd lo");
        exp_bus(10'h302, 2'b11, 1'b0, 16'h0, "R6 rd hi");
        exp_done({din_of(10'h302), din_of(10'h300)}, 1'b1, "R6 rd");
        issue(1'b0, 2'd3, gaddr(10'h300, 1'b0), 32'h0);
        illegal(2'd3, gaddr(10'h222, 1'b0), "R6 R10 misaligned pair");
        clear_err();

        // R7 word-spaced region
        exp_bus(10'h3FB, 2'b01, 1'b1, 16'h0042, "R7 wr");
        exp_done(32'h0, 1'b0, "R7 wr");
        issue(1'b1, 2'd0, waddr(10'h3FB), 32'h0000_0042);
        exp_bus(10'h37A, 2'b01, 1'b0, 16'h0, "R7 rd");
        exp_done({24'h0, din_of(10'h37A)[7:0]}, 1'b1, "R7 rd");
        issue(1'b0, 2'd0, waddr(10'h37A), 32'h0);
        exp_bus(10'h2F8, 2'b11, 1'b0, 16'h0, "R7 half");
        exp_done({16'h0, din_of(10'h2F8)}, 1'b1, "R7 half");
        issue(1'b0, 2'd1, waddr(10'h2F8), 32'h0);
        illegal(2'd0, waddr(10'h3E0), "R7 outside group");
        clear_err();
        illegal(2'd2, waddr(10'h3F8), "R7 word size");
        clear_err();

        // R11 request during transfer ignored
        exp_bus(10'h220, 2'b01, 1'b1, 16'h0011, "R11 wr");
        exp_done(32'h0, 1'b0, "R11 wr");
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_size = 2'd0;
        cpu_addr = gaddr(10'h220, 1'b0); cpu_wdata = 32'h11;
        @(negedge clk);
        cpu_size = 2'd2; cpu_addr = waddr(10'h3E0);
        repeat (2) @(negedge clk);
        cpu_req = 1'b0;
        while (!cpu_done) @(negedge clk);
        repeat (4) @(negedge clk);

        check(bus_q.size() == 0, "R11 bus queue drained", bus_q.size(), 0);
        check(done_q.size() == 0, "R9 done queue drained", done_q.size(), 0);
        finish_run();
    end

endmodule